// File: doc/BRIEF.md
# Half-Duplex Transmit Framer with Collision Jam

This block turns a byte stream into a 4-bit, nibble-wide transmit interface of the kind used by 10/100 Ethernet PHYs. A frame starts when the source presents its first byte. The framer first sends the preamble and start-of-frame delimiter. It then pulls the frame bytes one at a time and sends each byte as two nibbles, low nibble first. The frame check sequence is not generated here. The source supplies it as the tail of the byte stream, so the last input byte is the end of the CRC.

In half-duplex operation the framer watches a collision input for the whole time the preamble and frame bytes are on the wire. When a collision is seen, it stops sending data. It sends a fixed 32-bit jam, drops transmit enable, and discards what remains of the frame at the input. It then reports the collision as a one-cycle status pulse. The pulse is classified by whether the collision fell inside the first slot time (128 nibbles, counted from the first preamble nibble) or after it. In full-duplex operation the collision input has no effect. Backoff and retry are left to the logic above this block.

The source must keep `frm_valid` high from the first byte to the last. If the stream runs dry while a byte is needed, the frame ends early.

Top module: `hdx_tx_framer`

## Requirements
- R1: While reset is held and afterwards until a frame starts, `mii_txen` is 0, `mii_txd` is 0, `frm_ready` is 0 and both status pulses are 0. `mii_txd` is 0 in every cycle in which `mii_txen` is 0.
- R2: When `frm_valid` is high at a clock edge while idle, `mii_txen` rises in the next cycle. The block then sends 16 nibbles: 15 nibbles of 4'h5 followed by one nibble of 4'hD.
- R3: After the delimiter, each frame byte takes two consecutive cycles: bits [3:0] first, then bits [7:4]. `mii_txen` stays high without a gap and falls in the cycle after the high nibble of the byte flagged by `frm_last`.
- R4: A byte is taken at a clock edge where `frm_ready` and `frm_valid` are both high. `frm_ready` is high during the delimiter nibble and during the high nibble of every byte until the byte flagged by `frm_last` has been taken. Bytes reach the wire in the order they are taken.
- R5: In half-duplex (`half_duplex`=1), if `col_in` is high at the edge that ends the nibble with index c (index 0 is the first preamble nibble), the next nibble is the start of the jam: 8 nibbles of 4'h5. `mii_txen` falls right after the jam, so exactly c+9 nibbles are sent.
- R6: R5 also holds when c is the high nibble of the final byte. The jam then follows a complete frame.
- R7: One cycle after the last jam nibble, exactly one of `col_normal` (when c < 128) or `col_late` (when c >= 128) pulses for one cycle. Neither pulses at any other time.
- R8: After a jam, `frm_ready` stays high and input bytes are taken and dropped until the byte flagged by `frm_last` is taken. `mii_txen` stays 0 during this, and the block then returns to idle.
- R9: In full-duplex (`half_duplex`=0), `col_in` has no effect: the frame is sent whole and no status pulses.
- R10: `col_in` is ignored while the jam is being sent, while dropping input, and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Synchronous reset, active low |
| half_duplex | input | 1 | 1 enables collision handling and jam |
| col_in | input | 1 | Collision indication, sampled at clock edges |
| frm_valid | input | 1 | Source has a byte on `frm_data` |
| frm_data | input | 8 | Frame byte |
| frm_last | input | 1 | Marks the final byte of the frame (end of CRC) |
| frm_ready | output | 1 | Framer takes the byte at this edge if valid |
| mii_txd | output | 4 | Transmit nibble |
| mii_txen | output | 1 | Transmit enable |
| col_normal | output | 1 | One-cycle pulse: collision inside the slot time |
| col_late | output | 1 | One-cycle pulse: collision after the slot time |

## Verification
Two functions can land in the same clock edge. The first case is a collision on the last nibble of the frame, which is also the edge where normal completion would drop `mii_txen`. The second case is a collision on nibble 127 or nibble 128, where slot classification switches between normal and late. The bench sweeps the collision index over every nibble of a 70-byte frame, so both boundaries are covered. For each index it compares the whole nibble stream with one built arithmetically from the index, and checks which status pulse appears and in which cycle. It also checks that every input byte was consumed.

// File: rtl/hdx_pkg.sv
// Package: shared state encoding and wire codes for the half-duplex framer.
// Assumes nibbles leave the block low nibble first.
package hdx_pkg;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;

    localparam logic [NIB_W-1:0] NIB_PRE  = 4'h5;
    localparam logic [NIB_W-1:0] NIB_SFD  = 4'hD;
    localparam logic [NIB_W-1:0] NIB_JAM  = 4'h5;
    localparam logic [NIB_W-1:0] NIB_IDLE = 4'h0;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_DATA  = 3'd2,
        ST_JAM   = 3'd3,
        ST_DRAIN = 3'd4
    } txst_t;
endpackage

// File: rtl/hdx_slot_timer.sv
// Slot timer: counts nibbles sent since the frame began (preamble and
// data only) and saturates at SLOT_NIBBLES. past_slot is high once the
// current nibble index has reached the slot length.
// Assumes clr is held while the framer is idle.
module hdx_slot_timer #(
    parameter int SLOT_NIBBLES = 128,
    localparam int SW = $clog2(SLOT_NIBBLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic past_slot
);
    logic [SW-1:0] cnt_q;

    // Nibble counter, cleared between frames, saturating at the slot length.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q < SW'(SLOT_NIBBLES))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign past_slot = (cnt_q >= SW'(SLOT_NIBBLES));

    // R7: a fresh frame always starts inside the window
    a_r7_clear_inside_window: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !past_slot);
    // R7: once late, the window cannot be re-entered mid-frame
    a_r7_late_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (past_slot && !clr) |=> past_slot);
endmodule

// File: rtl/hdx_nib_sel.sv
// Nibble selector: decodes the registered framer state into the wire
// nibble and transmit enable. Purely combinational; the state it reads
// is registered, so outputs change only after clock edges.
module hdx_nib_sel
    import hdx_pkg::*;
#(
    parameter int PRE_NIBBLES = 16,
    parameter int CNT_W = 4
) (
    input  hdx_pkg::txst_t     st,
    input  logic [CNT_W-1:0]   cnt,
    input  logic [BYTE_W-1:0]  cur_byte,
    input  logic               phase_hi,
    output logic [NIB_W-1:0]   txd,
    output logic               txen
);
    // Pick the nibble for the current state and position.
    always_comb begin
        txen = 1'b0;
        txd  = NIB_IDLE;
        unique case (st)
            ST_PRE: begin
                txen = 1'b1;
                txd  = (cnt == CNT_W'(PRE_NIBBLES - 1)) ? NIB_SFD : NIB_PRE;
            end
            ST_DATA: begin
                txen = 1'b1;
                txd  = phase_hi ? cur_byte[BYTE_W-1:NIB_W] : cur_byte[NIB_W-1:0];
            end
            ST_JAM: begin
                txen = 1'b1;
                txd  = NIB_JAM;
            end
            default: begin
                txen = 1'b0;
                txd  = NIB_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/hdx_tx_ctrl.sv
// Framer control: sequences preamble, data, jam and drain. It runs the
// byte handshake and issues the collision status pulses.
// Assumes the source keeps frm_valid high through a frame; a missing
// byte when one is due ends the frame.
module hdx_tx_ctrl
    import hdx_pkg::*;
#(
    parameter int PRE_NIBBLES = 16,
    parameter int JAM_NIBBLES = 8,
    parameter int CNT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               half_duplex,
    input  logic               col_in,
    input  logic               frm_valid,
    input  logic [BYTE_W-1:0]  frm_data,
    input  logic               frm_last,
    input  logic               past_slot,
    output logic               frm_ready,
    output hdx_pkg::txst_t     st,
    output logic [CNT_W-1:0]   cnt,
    output logic [BYTE_W-1:0]  cur_byte,
    output logic               phase_hi,
    output logic               col_normal,
    output logic               col_late
);
    txst_t             st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] byte_q;
    logic              phase_q;
    logic              last_q;
    logic              late_q;
    logic              norm_p_q;
    logic              late_p_q;

    logic pre_end;
    logic jam_end;
    logic take;
    logic col_hit;

    assign pre_end = (st_q == ST_PRE) && (cnt_q == CNT_W'(PRE_NIBBLES - 1));
    assign jam_end = (st_q == ST_JAM) && (cnt_q == CNT_W'(JAM_NIBBLES - 1));

    // Ready when a byte is due next or input is being dropped.
    assign frm_ready = pre_end
                     || ((st_q == ST_DATA) && phase_q && !last_q)
                     || (st_q == ST_DRAIN);

    assign take    = frm_ready && frm_valid;
    assign col_hit = half_duplex && col_in && ((st_q == ST_PRE) || (st_q == ST_DATA));

    // State sequencer with collision override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            cnt_q    <= '0;
            phase_q  <= 1'b0;
            late_q   <= 1'b0;
            norm_p_q <= 1'b0;
            late_p_q <= 1'b0;
        end else begin
            norm_p_q <= 1'b0;
            late_p_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (frm_valid) begin
                        st_q  <= ST_PRE;
                        cnt_q <= '0;
                    end
                end
                ST_PRE: begin
                    if (col_hit) begin
                        st_q   <= ST_JAM;
                        cnt_q  <= '0;
                        late_q <= past_slot;
                    end else if (pre_end) begin
                        st_q    <= take ? ST_DATA : ST_IDLE;
                        phase_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (col_hit) begin
                        st_q   <= ST_JAM;
                        cnt_q  <= '0;
                        late_q <= past_slot;
                    end else if (!phase_q) begin
                        phase_q <= 1'b1;
                    end else if (take) begin
                        phase_q <= 1'b0;
                    end else begin
                        st_q <= ST_IDLE;
                    end
                end
                ST_JAM: begin
                    if (jam_end) begin
                        st_q     <= last_q ? ST_IDLE : ST_DRAIN;
                        norm_p_q <= !late_q;
                        late_p_q <= late_q;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (take && frm_last) begin
                        st_q <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Byte holding register and end-of-frame marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            last_q <= 1'b0;
        end else if (take) begin
            byte_q <= frm_data;
            last_q <= frm_last;
        end else if ((st_q == ST_IDLE) && frm_valid) begin
            last_q <= 1'b0;
        end
    end

    assign st         = st_q;
    assign cnt        = cnt_q;
    assign cur_byte   = byte_q;
    assign phase_hi   = phase_q;
    assign col_normal = norm_p_q;
    assign col_late   = late_p_q;

    // R9: full duplex never enters the jam from an active frame
    a_r9_no_jam_full_duplex: assert property (@(posedge clk) disable iff (!rst_n)
        (((st_q == ST_PRE) || (st_q == ST_DATA)) && !half_duplex) |=> (st_q != ST_JAM));
    // R5: the jam runs for its full length before leaving
    a_r5_jam_full_length: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_JAM) && !jam_end) |=> (st_q == ST_JAM));
    // R7: the two status pulses never coincide
    a_r7_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(col_normal && col_late));
    // R7: status only ever follows a jam
    a_r7_status_after_jam: assert property (@(posedge clk) disable iff (!rst_n)
        (col_normal || col_late) |-> ($past(st_q) == ST_JAM));
    // R8: dropping input ends only on a taken last byte
    a_r8_drain_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_DRAIN) && !(frm_valid && frm_last)) |=> (st_q == ST_DRAIN));
    // R2: the delimiter nibble is followed by data, a jam or idle
    a_r2_after_delim: assert property (@(posedge clk) disable iff (!rst_n)
        pre_end |=> (st_q != ST_PRE));
endmodule

// File: rtl/hdx_tx_framer.sv
// Top: half-duplex nibble-wide transmit framer with collision jam.
// Wires the control sequencer, slot timer and nibble selector together.
// Assumes the byte stream already carries the frame check sequence.
module hdx_tx_framer
    import hdx_pkg::*;
#(
    parameter int PRE_NIBBLES  = 16,
    parameter int JAM_NIBBLES  = 8,
    parameter int SLOT_NIBBLES = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        half_duplex,
    input  logic        col_in,
    input  logic        frm_valid,
    input  logic [7:0]  frm_data,
    input  logic        frm_last,
    output logic        frm_ready,
    output logic [3:0]  mii_txd,
    output logic        mii_txen,
    output logic        col_normal,
    output logic        col_late
);
    localparam int CNT_MAX = (PRE_NIBBLES > JAM_NIBBLES) ? PRE_NIBBLES : JAM_NIBBLES;
    localparam int CNT_W   = $clog2(CNT_MAX);

    txst_t             st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] cur_byte;
    logic              phase_hi;
    logic              past_slot;
    logic              slot_clr;
    logic              slot_tick;

    assign slot_clr  = (st == ST_IDLE);
    assign slot_tick = (st == ST_PRE) || (st == ST_DATA);

    hdx_tx_ctrl #(
        .PRE_NIBBLES (PRE_NIBBLES),
        .JAM_NIBBLES (JAM_NIBBLES),
        .CNT_W       (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .half_duplex (half_duplex),
        .col_in      (col_in),
        .frm_valid   (frm_valid),
        .frm_data    (frm_data),
        .frm_last    (frm_last),
        .past_slot   (past_slot),
        .frm_ready   (frm_ready),
        .st          (st),
        .cnt         (cnt),
        .cur_byte    (cur_byte),
        .phase_hi    (phase_hi),
        .col_normal  (col_normal),
        .col_late    (col_late)
    );

    hdx_slot_timer #(
        .SLOT_NIBBLES (SLOT_NIBBLES)
    ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (slot_clr),
        .tick      (slot_tick),
        .past_slot (past_slot)
    );

    hdx_nib_sel #(
        .PRE_NIBBLES (PRE_NIBBLES),
        .CNT_W       (CNT_W)
    ) u_nib (
        .st       (st),
        .cnt      (cnt),
        .cur_byte (cur_byte),
        .phase_hi (phase_hi),
        .txd      (mii_txd),
        .txen     (mii_txen)
    );

    // R1: an idle wire carries the zero nibble
    a_r1_quiet_wire: assert property (@(posedge clk) disable iff (!rst_n)
        !mii_txen |-> (mii_txd == 4'h0));
    // R3: enable can only rise out of the idle state
    a_r3_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mii_txen) |-> ($past(st) == ST_IDLE));
endmodule

// File: tb/sim_hdx_tx_framer.sv
// Bench: sweeps frame lengths, duplex mode and the collision position
// over every nibble of a frame, and rebuilds the expected wire stream
// arithmetically for each run.
module sim_hdx_tx_framer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       half_duplex = 1'b0;
    logic       col_in = 1'b0;
    logic       frm_valid = 1'b0;
    logic [7:0] frm_data = 8'h00;
    logic       frm_last = 1'b0;
    logic       frm_ready;
    logic [3:0] mii_txd;
    logic       mii_txen;
    logic       col_normal;
    logic       col_late;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    logic [3:0] got [0:511];

    always #2.5 clk = ~clk;

    hdx_tx_framer u0 (
        .clk(clk), .rst_n(rst_n), .half_duplex(half_duplex), .col_in(col_in),
        .frm_valid(frm_valid), .frm_data(frm_data), .frm_last(frm_last),
        .frm_ready(frm_ready), .mii_txd(mii_txd), .mii_txen(mii_txen),
        .col_normal(col_normal), .col_late(col_late)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'((k * 37) + (seed * 11) + 3);
    endfunction

    function automatic logic [3:0] exp_nib(input int seed, input int len, input int i);
        logic [7:0] b;
        if (i < 15) return 4'h5;
        if (i == 15) return 4'hD;
        if (i < 16 + 2 * len) begin
            b = pat(seed, (i - 16) / 2);
            return ((i - 16) % 2 == 0) ? b[3:0] : b[7:4];
        end
        return 4'h5;
    endfunction

    // Runs one frame; c < 0 means no collision.
    task automatic run_frame(input int len, input bit hd, input int c, input int seed,
                             input string req);
        int  idx = 0, n = 0, nn = 0, nl = 0, hold = 0, post = 0;
        bit  acc = 0, fell = 0, regrow = 0, quiet_bad = 0, mistime = 0, fired = 0, done = 0;
        int  exp_len, mism;
        half_duplex = hd;
        for (int cyc = 0; cyc < 3000 && !done; cyc++) begin
            @(negedge clk);
            if (acc) idx++;
            if (mii_txen) begin
                if (fell) regrow = 1;
                else begin
                    got[n] = mii_txd;
                    n++;
                end
            end
            if (!mii_txen && mii_txd != 4'h0) quiet_bad = 1;
            if (col_normal) nn++;
            if (col_late) nl++;
            if ((col_normal || col_late) && !(!mii_txen && n > 0 && !fell)) mistime = 1;
            if (!mii_txen && n > 0) fell = 1;
            if (mii_txen && !fired && c >= 0 && (n - 1) == c) begin
                fired = 1;
                hold = 3;
            end
            col_in = (hold > 0);
            if (hold > 0) hold--;
            acc = frm_ready && (idx < len);
            frm_valid = (idx < len);
            frm_data  = pat(seed, idx);
            frm_last  = (idx == len - 1);
            if (fell && idx == len && !acc) begin
                post++;
                if (post == 3) done = 1;
            end
        end
        frm_valid = 0;
        col_in = 0;
        check(done, {req, " frame completes"}, done, 1);
        exp_len = (hd && c >= 0) ? c + 9 : 16 + 2 * len;
        check(n == exp_len, {req, " nibble count"}, n, exp_len);
        mism = 0;
        for (int i = 0; i < n && i < exp_len; i++) begin
            if (i > ((hd && c >= 0) ? c : exp_len)) begin
                if (got[i] != 4'h5) mism++;
            end else if (got[i] != exp_nib(seed, len, i)) begin
                mism++;
            end
        end
        check(mism == 0, {req, " nibble content"}, mism, 0);
        check(idx == len && !regrow, {req, " R8 input consumed, no restart"}, idx, len);
        check(!quiet_bad, {req, " R1 idle nibble zero"}, quiet_bad, 0);
        if (hd && c >= 0) begin
            check(nn == ((c < 128) ? 1 : 0) && nl == ((c >= 128) ? 1 : 0) && !mistime,
                  {req, " R7 status kind/timing (normal count)"}, nn, (c < 128) ? 1 : 0);
        end else begin
            check(nn == 0 && nl == 0, {req, " R9 no status"}, nn + nl, 0);
        end
    endtask

    // Watchdog: an overrun counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        bit busy;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!mii_txen && mii_txd == 0 && !frm_ready && !col_normal && !col_late,
              "R1 in reset", mii_txen, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        check(!mii_txen && !frm_ready && !col_normal && !col_late,
              "R1 after reset", frm_ready, 0);

        // R2 R3 R4: short frames, both modes
        for (int l = 1; l <= 8; l++) begin
            run_frame(l, 1'b1, -1, l, "R2 R3 R4 half");
            run_frame(l, 1'b0, -1, l + 40, "R3 R4 full");
        end

        // R10: collision while idle is ignored
        half_duplex = 1;
        col_in = 1;
        busy = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (mii_txen || col_normal || col_late || frm_ready) busy = 1;
        end
        col_in = 0;
        check(!busy, "R10 idle collision ignored", busy, 0);
        run_frame(4, 1'b1, -1, 7, "R10 frame after idle collision");

        // R5 R6 R7 R8 R10: collision at every nibble index of a 70-byte frame
        for (int c = 0; c < 16 + 140; c++) begin
            run_frame(70, 1'b1, c, c, (c == 155) ? "R6 last nibble" :
                      (c == 127 || c == 128) ? "R7 slot edge" : "R5 R8 R10 sweep");
        end

        // R9: full duplex ignores collisions
        run_frame(70, 1'b0, 0, 1, "R9 full c0");
        run_frame(70, 1'b0, 20, 2, "R9 full c20");
        run_frame(70, 1'b0, 127, 3, "R9 full c127");
        run_frame(70, 1'b0, 128, 4, "R9 full c128");
        run_frame(70, 1'b0, 155, 5, "R9 full c155");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule